// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block keeps the bookkeeping for a circular table of receive buffer descriptors that software and a DMA engine share. Software posts free buffers at the add index. The DMA engine fills slots and writes back frame length and status. It also publishes the index of the descriptor it is working on now. Each post records the buffer address and the number of cache blocks the buffer touches, so the DMA engine can fetch both for any slot. The engine can also ask for the 16-byte-aligned address of a slot's descriptor.

A completion pass starts on a pulse and carries a work budget. Each cycle the pass looks at the slot at the remove index. It stops without consuming anything once that index reaches the hardware's live index or the ring is empty. Otherwise it consumes the slot and reports it on the completion outputs with a kind code. A good frame hands over a replacement buffer. An errored frame, or a good frame with no replacement on offer, has its own buffer posted back in place. A separate saturating 16-bit counter records frames the DMA engine lost for want of a descriptor. Reading it folds its value into a 32-bit running total and clears it.

Top module: `rx_dscr_ring`

## Requirements
- R1: `ring_full` is high exactly when the slot after the add index is the remove index, so at most DEPTH-1 buffers are held. A post offered while full is refused (`post_ready` low) and the add index does not move.
- R2: An accepted post stores its address in the slot at the add index, and the add index then advances by one, wrapping from DEPTH-1 to 0. `dma_rd_idx` returns the stored address of any slot.
- R3: The stored block count is (address mod BLK_BYTES + length + BLK_BYTES - 1) / BLK_BYTES. It counts every cache block the buffer touches, including a partial first block.
- R4: `dma_dscr_addr` equals TBL_BASE with its low four bits cleared, plus 16 times `dma_rd_idx`. It is therefore always 16-byte aligned.
- R5: A pass ends with `done_reason` 0 as soon as the remove index equals `hw_cur_idx` or the ring is empty. The slot at `hw_cur_idx` is never reported.
- R6: A slot whose status bit 0 (bad frame) is set is reported with `cmp_kind` 1. Its own buffer is posted back at the add index, and both indices advance.
- R7: A good slot with `repl_valid` high is reported with `cmp_kind` 0. The replacement buffer, with its block count, is posted at the add index, and both indices advance.
- R8: A good slot with `repl_valid` low is reported with `cmp_kind` 2. Its own buffer is posted back, both indices advance, and the pass ends in that same cycle with `done_reason` 2.
- R9: `cmp_csum_ok` is high only when status bit 1 (bad IPv4 header checksum) and status bit 2 (bad TCP checksum) are both clear.
- R10: A pass reports at most `pass_budget` slots. When the budget is spent before any other stop condition, the pass ends with `done_reason` 1.
- R11: Each `hw_ood_drop` pulse adds one to `ood_count`, which saturates at 0xFFFF. An `ood_rd` pulse adds the shown value to `ood_total` and clears the count. A drop in the same cycle as the read leaves the count at 1.
- R12: After reset both indices are 0, the ring is empty, no pass is active, and both drop counters read 0.
- R13: While a pass is active (`busy` high), posts are refused and the add index does not move because of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| post_valid | input | 1 | Software offers a free buffer |
| post_addr | input | AW | Address of the offered buffer |
| post_len | input | LW | Size in bytes of the offered buffer |
| post_ready | output | 1 | Offer taken this cycle |
| ring_full | output | 1 | No slot left to post into |
| ring_empty | output | 1 | Add and remove indices are equal |
| sw_add_idx | output | IW | Next slot to post into |
| sw_rem_idx | output | IW | Next slot to consume |
| dma_rd_idx | input | IW | Slot the DMA engine looks up |
| dma_rd_addr | output | AW | Buffer address of that slot |
| dma_rd_blocks | output | BW | Cache-block span of that slot |
| dma_dscr_addr | output | AW | Descriptor address of that slot |
| dma_wb_valid | input | 1 | DMA writes back a slot's status |
| dma_wb_idx | input | IW | Slot written back |
| dma_wb_len | input | LW | Received frame length |
| dma_wb_flags | input | 3 | Bit 0 bad frame, bit 1 bad IPv4 checksum, bit 2 bad TCP checksum |
| hw_cur_idx | input | IW | Slot the DMA engine is working on now |
| pass_start | input | 1 | Start a completion pass |
| pass_budget | input | BGW | Most slots the pass may report |
| repl_valid | input | 1 | A replacement buffer is on offer |
| repl_addr | input | AW | Replacement buffer address |
| repl_len | input | LW | Replacement buffer size |
| cmp_valid | output | 1 | A slot is consumed this cycle |
| cmp_kind | output | 2 | 0 delivered, 1 errored and recycled, 2 dropped for no replacement |
| cmp_idx | output | IW | Index of the consumed slot |
| cmp_addr | output | AW | Buffer address of the consumed slot |
| cmp_len | output | LW | Frame length of the consumed slot |
| cmp_csum_ok | output | 1 | Both checksum error flags clear |
| pass_done | output | 1 | Last cycle of the pass |
| done_reason | output | 2 | 0 caught up, 1 budget spent, 2 no replacement |
| busy | output | 1 | A pass is active |
| hw_ood_drop | input | 1 | DMA lost a frame for want of a descriptor |
| ood_rd | input | 1 | Read and clear the lost-frame count |
| ood_count | output | 16 | Current lost-frame count |
| ood_total | output | 32 | Running sum of every count read |

## Verification
If the remove index drifts, the completion outputs show the wrong buffer address or frame length on the very next consumed slot. It also shows in the pass ending one slot early or late against `hw_cur_idx`. A wrong add index shows at the next recycle or replacement: the table lookup at the expected slot returns a stale address, and `ring_full` changes state at the wrong fill level. A wrong span or counter value shows as soon as the affected slot is looked up or the count is read.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  typedef enum logic [1:0] {KIND_OK = 2'd0, KIND_ERR = 2'd1, KIND_NOBUF = 2'd2} cmp_kind_e;
  typedef enum logic [1:0] {DONE_CAUGHT_UP = 2'd0, DONE_BUDGET = 2'd1, DONE_NOBUF = 2'd2} done_e;
  typedef enum logic {ST_IDLE = 1'b0, ST_SCAN = 1'b1} scan_st_e;
  localparam int FLG_BAD     = 0;
  localparam int FLG_BAD_IP4 = 1;
  localparam int FLG_BAD_TCP = 2;
  localparam int FLG_W       = 3;
endpackage

// File: rtl/rxr_span.sv
module rxr_span #(
  parameter int LW        = 16,
  parameter int BLK_BYTES = 32,
  parameter int BW        = 13
) (
  input  logic [$clog2(BLK_BYTES)-1:0] addr_lo,
  input  logic [LW-1:0]                len,
  output logic [BW-1:0]                blocks
);
  localparam int LOG = $clog2(BLK_BYTES);
  localparam int SW  = LW + 2;
  logic [SW-1:0] sum;
  // offset inside the first block widens the span before rounding up
  assign sum    = SW'(len) + SW'(addr_lo) + SW'(BLK_BYTES - 1);
  assign blocks = BW'(sum >> LOG);
endmodule

// File: rtl/rxr_table.sv
module rxr_table import rxr_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int BW    = 13,
  parameter int IW    = 3
) (
  input  logic             clk,
  input  logic             buf_we,
  input  logic [IW-1:0]    buf_widx,
  input  logic [AW-1:0]    buf_waddr,
  input  logic [BW-1:0]    buf_wblocks,
  input  logic             wb_we,
  input  logic [IW-1:0]    wb_idx,
  input  logic [LW-1:0]    wb_len,
  input  logic [FLG_W-1:0] wb_flags,
  input  logic [IW-1:0]    rd_a_idx,
  output logic [AW-1:0]    rd_a_addr,
  output logic [BW-1:0]    rd_a_blocks,
  input  logic [IW-1:0]    rd_b_idx,
  output logic [AW-1:0]    rd_b_addr,
  output logic [BW-1:0]    rd_b_blocks,
  output logic [LW-1:0]    rd_b_len,
  output logic [FLG_W-1:0] rd_b_flags
);
  logic [AW-1:0]    addr_m [DEPTH];
  logic [BW-1:0]    blk_m  [DEPTH];
  logic [LW-1:0]    len_m  [DEPTH];
  logic [FLG_W-1:0] flg_m  [DEPTH];

  // storage flops: no reset, written only under explicit enables
  always_ff @(posedge clk) begin
    for (int s = 0; s < DEPTH; s++) begin
      if (buf_we && (buf_widx == IW'(s))) begin
        addr_m[s] <= buf_waddr;
        blk_m[s]  <= buf_wblocks;
      end
      if (wb_we && (wb_idx == IW'(s))) begin
        len_m[s] <= wb_len;
        flg_m[s] <= wb_flags;
      end else if (buf_we && (buf_widx == IW'(s))) begin
        len_m[s] <= '0;
        flg_m[s] <= '0;
      end
    end
  end

  assign rd_a_addr   = addr_m[rd_a_idx];
  assign rd_a_blocks = blk_m[rd_a_idx];
  assign rd_b_addr   = addr_m[rd_b_idx];
  assign rd_b_blocks = blk_m[rd_b_idx];
  assign rd_b_len    = len_m[rd_b_idx];
  assign rd_b_flags  = flg_m[rd_b_idx];
endmodule

// File: rtl/rxr_scan.sv
module rxr_scan import rxr_pkg::*; #(
  parameter int IW  = 3,
  parameter int BGW = 8
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           pass_start,
  input  logic [BGW-1:0] pass_budget,
  input  logic [IW-1:0]  rem_idx,
  input  logic [IW-1:0]  hw_cur_idx,
  input  logic           ring_empty,
  input  logic           slot_bad,
  input  logic           repl_valid,
  output logic           consume,
  output logic           repost_old,
  output logic           cmp_valid,
  output logic [1:0]     cmp_kind,
  output logic           pass_done,
  output logic [1:0]     done_reason,
  output logic           busy
);
  scan_st_e       st_q, st_d;
  logic [BGW-1:0] bud_q, bud_d;
  cmp_kind_e      kind;
  done_e          reason;
  logic           stop_hw, stop_bud;

  assign stop_hw  = ring_empty || (rem_idx == hw_cur_idx);
  assign stop_bud = (bud_q == '0);

  always_comb begin
    st_d       = st_q;
    bud_d      = bud_q;
    consume    = 1'b0;
    repost_old = 1'b0;
    cmp_valid  = 1'b0;
    kind       = KIND_OK;
    pass_done  = 1'b0;
    reason     = DONE_CAUGHT_UP;
    case (st_q)
      ST_IDLE: begin
        if (pass_start) begin
          st_d  = ST_SCAN;
          bud_d = pass_budget;
        end
      end
      ST_SCAN: begin
        if (stop_hw) begin
          pass_done = 1'b1;
          st_d      = ST_IDLE;
        end else if (stop_bud) begin
          pass_done = 1'b1;
          reason    = DONE_BUDGET;
          st_d      = ST_IDLE;
        end else begin
          consume   = 1'b1;
          cmp_valid = 1'b1;
          if (slot_bad) begin
            kind       = KIND_ERR;
            repost_old = 1'b1;
            bud_d      = bud_q - 1'b1;
          end else if (repl_valid) begin
            kind  = KIND_OK;
            bud_d = bud_q - 1'b1;
          end else begin
            kind       = KIND_NOBUF;
            repost_old = 1'b1;
            pass_done  = 1'b1;
            reason     = DONE_NOBUF;
            st_d       = ST_IDLE;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      bud_q <= '0;
    end else begin
      st_q  <= st_d;
      bud_q <= bud_d;
    end
  end

  assign busy        = (st_q == ST_SCAN);
  assign cmp_kind    = kind;
  assign done_reason = reason;

  AST_NOBUF_ENDS_PASS: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmp_valid && cmp_kind == KIND_NOBUF) |=> !busy); // R8
  AST_BUDGET_SPENT: assert property (@(posedge clk) disable iff (!rst_ni)
    cmp_valid |=> (!busy || (bud_q == $past(bud_q) - 1'b1))); // R10
endmodule

// File: rtl/rxr_oodcnt.sv
module rxr_oodcnt #(
  parameter int CW = 16,
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_ni,
  input  logic          drop,
  input  logic          rd,
  output logic [CW-1:0] count,
  output logic [TW-1:0] total
);
  localparam logic [CW-1:0] CMAX = '1;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [TW-1:0] tot_q, tot_d;

  always_comb begin
    cnt_d = rd ? '0 : cnt_q;
    tot_d = rd ? (tot_q + TW'(cnt_q)) : tot_q;
    if (drop) begin
      if (rd)                 cnt_d = CW'(1);
      else if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tot_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      tot_q <= tot_d;
    end
  end

  assign count = cnt_q;
  assign total = tot_q;

  AST_OOD_CLEARED: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd && !drop) |=> (count == '0)); // R11
  AST_OOD_SATURATE: assert property (@(posedge clk) disable iff (!rst_ni)
    (count == CMAX && !rd) |=> (count == CMAX)); // R11
endmodule

// File: rtl/rx_dscr_ring.sv
module rx_dscr_ring import rxr_pkg::*; #(
  parameter int          DEPTH     = 8,
  parameter int          AW        = 32,
  parameter int          LW        = 16,
  parameter int          BLK_BYTES = 32,
  parameter int          BGW       = 8,
  parameter logic [31:0] TBL_BASE  = 32'h0000_1000,
  localparam int         IW        = $clog2(DEPTH),
  localparam int         BW        = LW + 2 - $clog2(BLK_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_valid,
  input  logic [AW-1:0]    post_addr,
  input  logic [LW-1:0]    post_len,
  output logic             post_ready,
  output logic             ring_full,
  output logic             ring_empty,
  output logic [IW-1:0]    sw_add_idx,
  output logic [IW-1:0]    sw_rem_idx,
  input  logic [IW-1:0]    dma_rd_idx,
  output logic [AW-1:0]    dma_rd_addr,
  output logic [BW-1:0]    dma_rd_blocks,
  output logic [AW-1:0]    dma_dscr_addr,
  input  logic             dma_wb_valid,
  input  logic [IW-1:0]    dma_wb_idx,
  input  logic [LW-1:0]    dma_wb_len,
  input  logic [2:0]       dma_wb_flags,
  input  logic [IW-1:0]    hw_cur_idx,
  input  logic             pass_start,
  input  logic [BGW-1:0]   pass_budget,
  input  logic             repl_valid,
  input  logic [AW-1:0]    repl_addr,
  input  logic [LW-1:0]    repl_len,
  output logic             cmp_valid,
  output logic [1:0]       cmp_kind,
  output logic [IW-1:0]    cmp_idx,
  output logic [AW-1:0]    cmp_addr,
  output logic [LW-1:0]    cmp_len,
  output logic             cmp_csum_ok,
  output logic             pass_done,
  output logic [1:0]       done_reason,
  output logic             busy,
  input  logic             hw_ood_drop,
  input  logic             ood_rd,
  output logic [15:0]      ood_count,
  output logic [31:0]      ood_total
);
  localparam int LOG = $clog2(BLK_BYTES);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);
  localparam logic [AW-1:0] BASE_AL = AW'({TBL_BASE[31:4], 4'b0000});

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == LAST) ? '0 : i + 1'b1;
  endfunction

  // reset: asynchronous assert, synchronous release
  logic rst_meta, rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ni   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ni   <= rst_meta;
    end
  end

  logic [IW-1:0] add_q, add_d, rem_q, rem_d;
  logic          post_fire, consume, repost_old;
  logic [BW-1:0] span_post, span_repl;
  logic          buf_we;
  logic [AW-1:0] buf_waddr;
  logic [BW-1:0] buf_wblocks;
  logic [AW-1:0] slot_addr;
  logic [BW-1:0] slot_blocks;
  logic [LW-1:0] slot_len;
  logic [2:0]    slot_flags;

  assign ring_empty = (add_q == rem_q);
  assign ring_full  = (nxt(add_q) == rem_q);
  assign post_ready = post_valid && !ring_full && !busy;
  assign post_fire  = post_ready;

  always_comb begin
    add_d = add_q;
    rem_d = rem_q;
    if (post_fire || consume) add_d = nxt(add_q);
    if (consume)              rem_d = nxt(rem_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      add_q <= '0;
      rem_q <= '0;
    end else begin
      add_q <= add_d;
      rem_q <= rem_d;
    end
  end

  rxr_span #(.LW(LW), .BLK_BYTES(BLK_BYTES), .BW(BW)) u_span_post (
    .addr_lo(post_addr[LOG-1:0]), .len(post_len), .blocks(span_post));
  rxr_span #(.LW(LW), .BLK_BYTES(BLK_BYTES), .BW(BW)) u_span_repl (
    .addr_lo(repl_addr[LOG-1:0]), .len(repl_len), .blocks(span_repl));

  always_comb begin
    buf_we      = post_fire || consume;
    buf_waddr   = post_addr;
    buf_wblocks = span_post;
    if (consume) begin
      buf_waddr   = repost_old ? slot_addr   : repl_addr;
      buf_wblocks = repost_old ? slot_blocks : span_repl;
    end
  end

  rxr_table #(.DEPTH(DEPTH), .AW(AW), .LW(LW), .BW(BW), .IW(IW)) u_table (
    .clk         (clk),
    .buf_we      (buf_we),
    .buf_widx    (add_q),
    .buf_waddr   (buf_waddr),
    .buf_wblocks (buf_wblocks),
    .wb_we       (dma_wb_valid),
    .wb_idx      (dma_wb_idx),
    .wb_len      (dma_wb_len),
    .wb_flags    (dma_wb_flags),
    .rd_a_idx    (dma_rd_idx),
    .rd_a_addr   (dma_rd_addr),
    .rd_a_blocks (dma_rd_blocks),
    .rd_b_idx    (rem_q),
    .rd_b_addr   (slot_addr),
    .rd_b_blocks (slot_blocks),
    .rd_b_len    (slot_len),
    .rd_b_flags  (slot_flags)
  );

  rxr_scan #(.IW(IW), .BGW(BGW)) u_scan (
    .clk         (clk),
    .rst_ni      (rst_ni),
    .pass_start  (pass_start),
    .pass_budget (pass_budget),
    .rem_idx     (rem_q),
    .hw_cur_idx  (hw_cur_idx),
    .ring_empty  (ring_empty),
    .slot_bad    (slot_flags[FLG_BAD]),
    .repl_valid  (repl_valid),
    .consume     (consume),
    .repost_old  (repost_old),
    .cmp_valid   (cmp_valid),
    .cmp_kind    (cmp_kind),
    .pass_done   (pass_done),
    .done_reason (done_reason),
    .busy        (busy)
  );

  rxr_oodcnt #(.CW(16), .TW(32)) u_ood (
    .clk    (clk),
    .rst_ni (rst_ni),
    .drop   (hw_ood_drop),
    .rd     (ood_rd),
    .count  (ood_count),
    .total  (ood_total)
  );

  assign sw_add_idx    = add_q;
  assign sw_rem_idx    = rem_q;
  assign cmp_idx       = rem_q;
  assign cmp_addr      = slot_addr;
  assign cmp_len       = slot_len;
  assign cmp_csum_ok   = !slot_flags[FLG_BAD_IP4] && !slot_flags[FLG_BAD_TCP];
  assign dma_dscr_addr = BASE_AL + AW'({dma_rd_idx, 4'b0000});

  logic [IW:0] occ;
  assign occ = (add_q >= rem_q) ? ((IW+1)'(add_q) - (IW+1)'(rem_q))
                                : ((IW+1)'(DEPTH) - (IW+1)'(rem_q) + (IW+1)'(add_q));

  AST_FULL_HOLDS_ADD: assert property (@(posedge clk) disable iff (!rst_ni)
    (post_valid && ring_full && !busy) |=> (add_q == $past(add_q))); // R1
  AST_REM_STEP: assert property (@(posedge clk) disable iff (!rst_ni)
    (rem_q != $past(rem_q)) |-> (rem_q == nxt($past(rem_q)))); // R2
  AST_OCC_KEPT: assert property (@(posedge clk) disable iff (!rst_ni)
    cmp_valid |=> (occ == $past(occ))); // R6
endmodule

// File: tb/tb_rx_dscr_ring.sv
module tb_rx_dscr_ring;
  localparam int DEPTH = 8, AW = 32, LW = 16, BGW = 8, IW = 3, BW = 13;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic post_valid = 0; logic [AW-1:0] post_addr = '0; logic [LW-1:0] post_len = '0;
  logic post_ready, ring_full, ring_empty;
  logic [IW-1:0] sw_add_idx, sw_rem_idx;
  logic [IW-1:0] dma_rd_idx = '0;
  logic [AW-1:0] dma_rd_addr, dma_dscr_addr;
  logic [BW-1:0] dma_rd_blocks;
  logic dma_wb_valid = 0; logic [IW-1:0] dma_wb_idx = '0; logic [LW-1:0] dma_wb_len = '0;
  logic [2:0] dma_wb_flags = '0;
  logic [IW-1:0] hw_cur_idx = '0;
  logic pass_start = 0; logic [BGW-1:0] pass_budget = '0;
  logic repl_valid = 0; logic [AW-1:0] repl_addr = '0; logic [LW-1:0] repl_len = '0;
  logic cmp_valid, cmp_csum_ok, pass_done, busy;
  logic [1:0] cmp_kind, done_reason;
  logic [IW-1:0] cmp_idx;
  logic [AW-1:0] cmp_addr;
  logic [LW-1:0] cmp_len;
  logic hw_ood_drop = 0, ood_rd = 0;
  logic [15:0] ood_count;
  logic [31:0] ood_total;

  rx_dscr_ring dut (.*);

  int n_tests = 0, n_fail = 0, n_cmp = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] baddr(input int i);
    return 32'h1_0000 + i * 32'h100 + i * 3;
  endfunction
  function automatic int blk(input logic [AW-1:0] a, input int l);
    return (int'(a % 32) + l + 31) / 32;
  endfunction

  typedef struct packed {
    logic [1:0] kind; logic [IW-1:0] idx; logic [AW-1:0] addr; logic [LW-1:0] len; logic csum;
  } exp_t;
  exp_t exp_q[$];

  task automatic push_exp(input logic [1:0] k, input int i, input logic [AW-1:0] a,
                          input int l, input logic c);
    exp_t e;
    e.kind = k; e.idx = IW'(i); e.addr = a; e.len = LW'(l); e.csum = c;
    exp_q.push_back(e);
  endtask

  // monitor: pops one expected item per reported slot
  always @(negedge clk) begin
    if (rst_n && cmp_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        check(0, "R5 unexpected slot", cmp_idx, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(cmp_kind == e.kind, "R6/R7/R8 kind", cmp_kind, e.kind);
        check(cmp_idx  == e.idx,  "R5 idx", cmp_idx, e.idx);
        check(cmp_addr == e.addr, "R2 addr", cmp_addr, e.addr);
        check(cmp_len  == e.len,  "R7 len", cmp_len, e.len);
        check(cmp_csum_ok == e.csum, "R9 csum", cmp_csum_ok, e.csum);
      end
    end
  end

  task automatic post(input logic [AW-1:0] a, input int l, input bit exp_ok, input string req);
    @(posedge clk); #1;
    post_valid = 1; post_addr = a; post_len = LW'(l);
    @(negedge clk);
    check(post_ready == exp_ok, req, post_ready, exp_ok);
    @(posedge clk); #1;
    post_valid = 0;
  endtask

  task automatic wb(input int i, input int l, input logic [2:0] f);
    @(posedge clk); #1;
    dma_wb_valid = 1; dma_wb_idx = IW'(i); dma_wb_len = LW'(l); dma_wb_flags = f;
    @(posedge clk); #1;
    dma_wb_valid = 0;
  endtask

  task automatic run_pass(input int budget, input int exp_reason, input int exp_n, input string req);
    int guard;
    n_cmp = 0;
    @(posedge clk); #1;
    pass_start = 1; pass_budget = BGW'(budget);
    @(posedge clk); #1;
    pass_start = 0;
    guard = 0;
    @(negedge clk);
    while (!pass_done && guard < 50) begin
      @(negedge clk); guard++;
    end
    check(pass_done == 1'b1, req, pass_done, 1);
    check(done_reason == 2'(exp_reason), req, done_reason, exp_reason);
    @(posedge clk); #1;
    check(n_cmp == exp_n, "R10 slots per pass", n_cmp, exp_n);
  endtask

  task automatic lookup(input int i, input logic [AW-1:0] a, input int b, input string req);
    @(posedge clk); #1;
    dma_rd_idx = IW'(i);
    @(negedge clk);
    check(dma_rd_addr == a, req, dma_rd_addr, a);
    check(dma_rd_blocks == BW'(b), "R3 span", dma_rd_blocks, b);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R12 reset state
    check(sw_add_idx == 0 && sw_rem_idx == 0, "R12 indices", sw_add_idx, 0);
    check(ring_empty && !ring_full && !busy, "R12 flags", {ring_empty, ring_full, busy}, 3'b100);
    check(ood_count == 0 && ood_total == 0, "R12 counters", ood_count, 0);

    for (int i = 0; i < 3; i++) post(baddr(i), 60 + i, 1, "R2 post");

    // R13: post during an active pass (rem == hw_cur, so the pass ends at once)
    hw_cur_idx = 0;
    @(posedge clk); #1;
    pass_start = 1; pass_budget = 8'd4;
    @(posedge clk); #1;
    pass_start = 0; post_valid = 1; post_addr = 32'hdead_0000; post_len = 16'd8;
    @(negedge clk);
    check(busy && !post_ready, "R13 refused while busy", post_ready, 0);
    check(pass_done && done_reason == 2'd0, "R5 stop at hw index", done_reason, 0);
    @(posedge clk); #1;
    post_valid = 0;
    @(negedge clk);
    check(sw_add_idx == 3, "R13 add unmoved", sw_add_idx, 3);

    for (int i = 3; i < 7; i++) post(baddr(i), 60 + i, 1, "R2 post");
    @(negedge clk);
    check(ring_full && sw_add_idx == 7, "R1 full at DEPTH-1", {ring_full, sw_add_idx}, {1'b1, 3'd7});
    post(32'hbeef_0000, 4, 0, "R1 refused when full");
    @(negedge clk);
    check(sw_add_idx == 7, "R1 add unmoved", sw_add_idx, 7);

    for (int i = 0; i < 7; i++) lookup(i, baddr(i), blk(baddr(i), 60 + i), "R2 stored addr");
    @(posedge clk); #1 dma_rd_idx = 3'd5;
    @(negedge clk);
    check(dma_dscr_addr == 32'h1050, "R4 dscr addr", dma_dscr_addr, 32'h1050);

    // status writebacks: bit0 bad, bit1 bad ip4, bit2 bad tcp
    wb(0, 100, 3'b000); wb(1, 101, 3'b001); wb(2, 102, 3'b010);
    wb(3, 103, 3'b100); wb(4, 104, 3'b000); wb(5, 105, 3'b000); wb(6, 106, 3'b000);

    // pass 1: budget of 3 spent first
    hw_cur_idx = 6; repl_valid = 1; repl_addr = 32'h2_0000; repl_len = 16'd64;
    push_exp(2'd0, 0, baddr(0), 100, 1);
    push_exp(2'd1, 1, baddr(1), 101, 1);
    push_exp(2'd0, 2, baddr(2), 102, 0);
    run_pass(3, 1, 3, "R10 budget stop");
    @(negedge clk);
    check(sw_add_idx == 2 && sw_rem_idx == 3, "R2 wrap of add", {sw_add_idx, sw_rem_idx}, {3'd2, 3'd3});
    check(ring_full, "R1 still full after recycling", ring_full, 1);
    lookup(0, baddr(1), blk(baddr(1), 61), "R6 bad buffer reposted");
    lookup(7, 32'h2_0000, 2, "R7 replacement posted");

    // pass 2: caught up with hardware, slot 6 never reported
    push_exp(2'd0, 3, baddr(3), 103, 0);
    push_exp(2'd0, 4, baddr(4), 104, 1);
    push_exp(2'd0, 5, baddr(5), 105, 1);
    run_pass(10, 0, 3, "R5 stop at hw index");
    @(negedge clk);
    check(sw_rem_idx == 6, "R5 hw slot kept", sw_rem_idx, 6);

    // pass 3: no replacement available
    hw_cur_idx = 1; repl_valid = 0;
    push_exp(2'd2, 6, baddr(6), 106, 1);
    run_pass(10, 2, 1, "R8 no replacement stop");
    @(negedge clk);
    check(sw_rem_idx == 7 && sw_add_idx == 6, "R8 indices", {sw_add_idx, sw_rem_idx}, {3'd6, 3'd7});
    lookup(5, baddr(6), blk(baddr(6), 66), "R8 old buffer reposted");
    check(exp_q.size() == 0, "R5 all expected slots seen", exp_q.size(), 0);

    // R11 lost-frame counter
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1 hw_ood_drop = 1;
    end
    @(posedge clk); #1 hw_ood_drop = 0;
    @(negedge clk);
    check(ood_count == 5, "R11 count", ood_count, 5);
    @(posedge clk); #1 hw_ood_drop = 1; ood_rd = 1;
    @(posedge clk); #1 hw_ood_drop = 0; ood_rd = 0;
    @(negedge clk);
    check(ood_count == 1 && ood_total == 5, "R11 read with drop", {ood_count, ood_total}, {16'd1, 32'd5});
    @(posedge clk); #1 ood_rd = 1;
    @(posedge clk); #1 ood_rd = 0;
    @(negedge clk);
    check(ood_count == 0 && ood_total == 6, "R11 read clears", {ood_count, ood_total}, {16'd0, 32'd6});
    @(posedge clk); #1 hw_ood_drop = 1;
    repeat (65537) @(posedge clk);
    #1 hw_ood_drop = 0;
    @(negedge clk);
    check(ood_count == 16'hFFFF, "R11 saturation", ood_count, 16'hFFFF);
    @(posedge clk); #1 ood_rd = 1;
    @(posedge clk); #1 ood_rd = 0;
    @(negedge clk);
    check(ood_total == 32'd65541 && ood_count == 0, "R11 total", ood_total, 65541);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1_500_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule